// File: doc/BRIEF.md
# Multicycle Unit Issue Scoreboard

This block sits in the decode stage of an in-order pipeline whose functional units take different numbers of cycles to produce a result. It keeps a small table of operations that have been issued but have not yet written their result back. For each such operation it records the destination register, whether the operation occupies the divider, and how many cycles remain until write-back. Every cycle it looks at the instruction waiting in decode and decides, without any clock delay, whether that instruction may leave decode. If it may not, it reports a two-bit reason.

An instruction is stalled in four cases. The first is a structural conflict: the divider is still busy, or the tracking table is full. The second is a read of a register whose producer has not reached its write-back cycle. The third is a write to a register that an older operation will still write. The fourth is a result that would land on the single register-file write port in the same cycle as an older result. A result becomes readable in its write-back cycle through a bypass. The block also drives the write-back grant, which names the register being written in the current cycle.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset the table is empty: `wb_valid` is 0 and a valid instruction with any operands issues with reason code 00.
- R2: While `dec_valid` is 0, `issue` is 0, `hazard` is 00 and nothing is added to the table, so no write-back grant later appears for that input.
- R3: Unit codes map to latencies as follows: 0 integer ALU 1, 1 memory 2, 2 FP add 4, 3 FP multiply 7, 4 FP divide 25, and codes 5 to 7 behave as the integer ALU. An operation issued in cycle t drives `wb_valid`=1 with `wb_reg` equal to its destination in cycle t+latency, for that single cycle only.
- R4: A nonzero source register equal to the destination of a tracked operation that has not reached its write-back cycle stalls with code 10. In the producer's write-back cycle the source no longer stalls.
- R5: A nonzero destination equal to the destination of a tracked operation that has not reached its write-back cycle stalls with code 11.
- R6: An instruction whose write-back cycle would equal that of a tracked operation stalls with code 11, so at most one write-back grant is given per cycle.
- R7: A divide presented while an earlier divide is within its 25-cycle initiation interval stalls with code 01. A divide presented exactly 25 cycles after the previous one may issue. Other units are unaffected by the divider.
- R8: The table holds eight operations. An operation occupies its entry from the cycle after issue through its write-back cycle. When all eight entries are occupied, any instruction stalls with code 01.
- R9: When several reasons apply, the lowest nonzero code is reported: 01 before 10 before 11.
- R10: Register 0 never causes a code 10 or a code 11 through register matching.
- R11: `issue` is 1 exactly when `dec_valid` is 1 and the code is 00. A stalled instruction leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_unit | input | 3 | Functional unit code of the decode instruction |
| dec_dst | input | 5 | Destination register |
| dec_src_a | input | 5 | First source register |
| dec_src_b | input | 5 | Second source register |
| issue | output | 1 | Instruction leaves decode this cycle |
| hazard | output | 2 | Stall reason: 00 none, 01 structural, 10 RAW, 11 write port or WAW |
| wb_valid | output | 1 | A tracked operation writes back this cycle |
| wb_reg | output | 5 | Register written this cycle |

## Verification
The bench aims at off-by-one boundaries. A divide is presented at 24 and at 25 cycles after the previous divide. A dependent read is presented one cycle before and exactly in the write-back cycle of a memory load. An ALU operation is placed so that its result would collide with a multiply's. A design off by one cycle would either stall a legal instruction or let two results share the write port. Filling all eight entries, then freeing one, checks that a design does not count a finishing entry as occupied after its write-back cycle, and does not let a ninth operation in. Overlapping reasons and register 0 operands check that the priority order holds and that the zero register never matches.

// File: rtl/issue_sb_pkg.sv
package issue_sb_pkg;

    localparam int REG_W = 5;
    localparam int CNT_W = 6;
    localparam int UNIT_W = 3;

    typedef enum logic [UNIT_W-1:0] {
        U_ALU  = 3'd0,
        U_MEM  = 3'd1,
        U_FADD = 3'd2,
        U_FMUL = 3'd3,
        U_FDIV = 3'd4
    } unit_e;

    typedef enum logic [1:0] {
        HZ_NONE   = 2'b00,
        HZ_STRUCT = 2'b01,
        HZ_RAW    = 2'b10,
        HZ_WRITE  = 2'b11
    } hazard_e;

    typedef struct packed {
        logic             valid;
        logic             is_div;
        logic [REG_W-1:0] dst;
        logic [CNT_W-1:0] rem;
    } slot_t;

    function automatic logic reg_hit(input logic [REG_W-1:0] a,
                                     input logic [REG_W-1:0] b);
        return (a != '0) && (a == b);
    endfunction

endpackage

// File: rtl/sb_track.sv
module sb_track
    import issue_sb_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc,
    input  logic                   alloc_div,
    input  logic [REG_W-1:0]       alloc_dst,
    input  logic [CNT_W-1:0]       alloc_lat,
    output slot_t [NSLOT-1:0]      slots,
    output logic                   wb_valid,
    output logic [REG_W-1:0]       wb_reg
);
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    slot_t [NSLOT-1:0] slots_q;
    logic [SLOT_W-1:0] free_idx;
    logic              free_hit;
    logic [NSLOT-1:0]  wb_vec;

    assign slots = slots_q;

    always_comb begin
        free_hit = 1'b0;
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!slots_q[i].valid) begin
                free_hit = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    always_comb begin
        wb_valid = 1'b0;
        wb_reg   = '0;
        for (int i = 0; i < NSLOT; i++) begin
            wb_vec[i] = slots_q[i].valid && (slots_q[i].rem == CNT_W'(1));
            if (wb_vec[i]) begin
                wb_valid = 1'b1;
                wb_reg   = slots_q[i].dst;
            end
        end
    end

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slots_q[g] <= '0;
                end else if (alloc && free_hit && (free_idx == SLOT_W'(g))) begin
                    slots_q[g].valid  <= 1'b1;
                    slots_q[g].is_div <= alloc_div;
                    slots_q[g].dst    <= alloc_dst;
                    slots_q[g].rem    <= alloc_lat;
                end else if (slots_q[g].valid) begin
                    if (slots_q[g].rem == CNT_W'(1)) begin
                        slots_q[g].valid <= 1'b0;
                        slots_q[g].rem   <= '0;
                    end else begin
                        slots_q[g].rem <= slots_q[g].rem - CNT_W'(1);
                    end
                end
            end
        end
    endgenerate

    assert_alloc_has_room_R8: assert property (@(posedge clk) disable iff (rst)
        alloc |-> free_hit);

    assert_single_writeback_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_vec));

endmodule

// File: rtl/sb_check.sv
module sb_check
    import issue_sb_pkg::*;
#(
    parameter int NSLOT   = 8,
    parameter int DIV_LAT = 25,
    parameter int DIV_II  = 25
) (
    input  slot_t [NSLOT-1:0]  slots,
    input  logic               dec_valid,
    input  logic               dec_div,
    input  logic [REG_W-1:0]   dec_dst,
    input  logic [REG_W-1:0]   dec_src_a,
    input  logic [REG_W-1:0]   dec_src_b,
    input  logic [CNT_W-1:0]   dec_lat,
    output logic               issue,
    output hazard_e            hazard
);
    localparam int BUSY_FLOOR = DIV_LAT - DIV_II + 1;

    logic raw, waw, port, div_busy, full;
    logic [CNT_W-1:0] land_rem;

    assign land_rem = dec_lat + CNT_W'(1);

    always_comb begin
        raw      = 1'b0;
        waw      = 1'b0;
        port     = 1'b0;
        div_busy = 1'b0;
        full     = 1'b1;
        for (int i = 0; i < NSLOT; i++) begin
            if (!slots[i].valid) full = 1'b0;
            if (slots[i].valid && slots[i].rem > CNT_W'(1)) begin
                if (reg_hit(dec_src_a, slots[i].dst) || reg_hit(dec_src_b, slots[i].dst))
                    raw = 1'b1;
                if (reg_hit(dec_dst, slots[i].dst))
                    waw = 1'b1;
            end
            if (slots[i].valid && slots[i].rem == land_rem)
                port = 1'b1;
            if (dec_div && slots[i].valid && slots[i].is_div &&
                slots[i].rem > CNT_W'(BUSY_FLOOR))
                div_busy = 1'b1;
        end
    end

    always_comb begin
        if (!dec_valid)            hazard = HZ_NONE;
        else if (div_busy || full) hazard = HZ_STRUCT;
        else if (raw)              hazard = HZ_RAW;
        else if (waw || port)      hazard = HZ_WRITE;
        else                       hazard = HZ_NONE;
    end

    assign issue = dec_valid && (hazard == HZ_NONE);

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import issue_sb_pkg::*;
#(
    parameter int NSLOT    = 8,
    parameter int LAT_ALU  = 1,
    parameter int LAT_MEM  = 2,
    parameter int LAT_FADD = 4,
    parameter int LAT_FMUL = 7,
    parameter int LAT_FDIV = 25,
    parameter int DIV_II   = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [2:0]       dec_unit,
    input  logic [4:0]       dec_dst,
    input  logic [4:0]       dec_src_a,
    input  logic [4:0]       dec_src_b,
    output logic             issue,
    output logic [1:0]       hazard,
    output logic             wb_valid,
    output logic [4:0]       wb_reg
);
    localparam int BUSY_FLOOR = LAT_FDIV - DIV_II + 1;

    slot_t [NSLOT-1:0] slots;
    logic [CNT_W-1:0]  dec_lat;
    logic              dec_div;
    hazard_e           hz;

    always_comb begin
        dec_div = 1'b0;
        case (unit_e'(dec_unit))
            U_MEM:   dec_lat = CNT_W'(LAT_MEM);
            U_FADD:  dec_lat = CNT_W'(LAT_FADD);
            U_FMUL:  dec_lat = CNT_W'(LAT_FMUL);
            U_FDIV: begin
                dec_lat = CNT_W'(LAT_FDIV);
                dec_div = 1'b1;
            end
            default: dec_lat = CNT_W'(LAT_ALU);
        endcase
    end

    sb_check #(
        .NSLOT  (NSLOT),
        .DIV_LAT(LAT_FDIV),
        .DIV_II (DIV_II)
    ) u_check (
        .slots    (slots),
        .dec_valid(dec_valid),
        .dec_div  (dec_div),
        .dec_dst  (dec_dst),
        .dec_src_a(dec_src_a),
        .dec_src_b(dec_src_b),
        .dec_lat  (dec_lat),
        .issue    (issue),
        .hazard   (hz)
    );

    sb_track #(
        .NSLOT(NSLOT)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .alloc    (issue),
        .alloc_div(dec_div),
        .alloc_dst(dec_dst),
        .alloc_lat(dec_lat),
        .slots    (slots),
        .wb_valid (wb_valid),
        .wb_reg   (wb_reg)
    );

    assign hazard = hz;

    // invariants over the tracked state
    logic [NSLOT-1:0] occupied;
    logic [NSLOT-1:0] div_window;
    logic             dup_dest;

    always_comb begin
        dup_dest = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            occupied[i]   = slots[i].valid;
            div_window[i] = slots[i].valid && slots[i].is_div &&
                            (slots[i].rem > CNT_W'(BUSY_FLOOR));
            for (int j = i + 1; j < NSLOT; j++) begin
                if (slots[i].valid && slots[j].valid &&
                    slots[i].rem > CNT_W'(1) && slots[j].rem > CNT_W'(1) &&
                    reg_hit(slots[i].dst, slots[j].dst))
                    dup_dest = 1'b1;
            end
        end
    end

    assert_issue_needs_valid_R11: assert property (@(posedge clk) disable iff (rst)
        issue |-> dec_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (hazard == 2'b00) && !issue);

    assert_alu_lands_next_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && dec_lat == CNT_W'(1)) |=> (wb_valid && wb_reg == $past(dec_dst)));

    assert_no_twin_dest_R5: assert property (@(posedge clk) disable iff (rst)
        !dup_dest);

    assert_one_divide_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(div_window));

    assert_full_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (&occupied) |-> !issue);

endmodule

// File: tb/issue_scoreboard_test.sv
`timescale 1ns/1ps
module issue_scoreboard_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_valid = 1'b0;
    logic [2:0] dec_unit = '0;
    logic [4:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic       issue;
    logic [1:0] hazard;
    logic       wb_valid;
    logic [4:0] wb_reg;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // model of tracked operations
    bit mv [8];
    int mrem [8];
    int mdst [8];
    bit mdiv [8];

    always #4 clk = ~clk;

    issue_scoreboard uut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_unit(dec_unit),
        .dec_dst(dec_dst), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .issue(issue), .hazard(hazard), .wb_valid(wb_valid), .wb_reg(wb_reg)
    );

    function automatic int lat_of(int u);
        case (u)
            1: return 2;
            2: return 4;
            3: return 7;
            4: return 25;
            default: return 1;
        endcase
    endfunction

    function automatic int model_code(int v, int u, int d, int a, int b);
        bit st, raw, wr;
        int cnt;
        st = 0; raw = 0; wr = 0; cnt = 0;
        if (v == 0) return 0;
        for (int i = 0; i < 8; i++) begin
            if (mv[i]) begin
                cnt++;
                if (mrem[i] > 1) begin
                    if ((a != 0 && a == mdst[i]) || (b != 0 && b == mdst[i])) raw = 1;
                    if (d != 0 && d == mdst[i]) wr = 1;
                    if (u == 4 && mdiv[i]) st = 1;
                end
                if (mrem[i] == lat_of(u) + 1) wr = 1;
            end
        end
        if (cnt == 8) st = 1;
        if (st) return 1;
        if (raw) return 2;
        if (wr) return 3;
        return 0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(int v, int u, int d, int a, int b, int exp, string req);
        int code, ewb, ereg, slot;
        @(negedge clk);
        dec_valid = v[0]; dec_unit = u[2:0]; dec_dst = d[4:0];
        dec_src_a = a[4:0]; dec_src_b = b[4:0];
        #1;
        code = model_code(v, u, d, a, b);
        if (exp >= 0) check(hazard == exp[1:0], req, "hazard code", hazard, exp);
        check(hazard == code[1:0], (exp >= 0) ? req : "R9", "hazard vs model", hazard, code);
        check(issue == (v != 0 && code == 0), "R11", "issue", issue, (v != 0 && code == 0));
        ewb = 0; ereg = 0;
        for (int i = 0; i < 8; i++)
            if (mv[i] && mrem[i] == 1) begin ewb = 1; ereg = mdst[i]; end
        check(wb_valid == ewb[0], "R3", "wb_valid", wb_valid, ewb);
        if (ewb != 0) check(wb_reg == ereg[4:0], "R3", "wb_reg", wb_reg, ereg);
        // advance the model across the coming edge
        slot = -1;
        for (int i = 7; i >= 0; i--) if (!mv[i]) slot = i;
        for (int i = 0; i < 8; i++)
            if (mv[i]) begin
                if (mrem[i] == 1) mv[i] = 0; else mrem[i]--;
            end
        if (v != 0 && code == 0 && slot >= 0) begin
            mv[slot] = 1; mrem[slot] = lat_of(u); mdst[slot] = d; mdiv[slot] = (u == 4);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, -1, "R2");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mv[i] = 0; mrem[i] = 0; mdst[i] = 0; mdiv[i] = 0; end
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: empty after reset
        #1 check(wb_valid == 1'b0, "R1", "wb_valid after reset", wb_valid, 0);
        step(1, 0, 3, 1, 2, 0, "R1");
        idle(3);

        // R4/R9: memory producer, dependent read one cycle early then in write-back cycle
        step(1, 1, 6, 0, 0, 0, "R3");
        step(1, 0, 7, 6, 0, 2, "R4");   // RAW and port both apply: 10 wins
        step(1, 0, 7, 0, 6, 0, "R4");   // bypass in write-back cycle
        idle(4);

        // R10: register 0 never matches
        step(1, 2, 0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, 0, 0, "R10");
        idle(6);

        // R5: WAW
        step(1, 3, 9, 0, 0, 0, "R5");
        step(1, 0, 9, 1, 2, 3, "R5");
        idle(10);

        // R6: write-port collision with a multiply, R2 idle inputs ignored
        step(1, 3, 10, 0, 0, 0, "R6");
        for (int k = 0; k < 5; k++) step(0, 3, 10, 10, 10, 0, "R2");
        step(1, 0, 11, 0, 0, 3, "R6");
        step(1, 0, 11, 0, 0, 0, "R6");
        idle(10);

        // R7: divider initiation interval
        step(1, 4, 12, 0, 0, 0, "R7");
        step(1, 4, 13, 0, 0, 1, "R7");
        step(1, 0, 14, 0, 0, 0, "R7");
        idle(21);
        step(1, 4, 13, 0, 0, 1, "R7");  // 24 cycles after first divide
        step(1, 4, 13, 0, 0, 0, "R7");  // 25 cycles after
        idle(30);

        // R8: fill all eight entries
        step(1, 4, 1, 0, 0, 0, "R8");
        for (int k = 0; k < 7; k++) step(1, 3, 2 + k, 0, 0, 0, "R8");
        step(1, 0, 20, 0, 0, 1, "R9");  // full and port collision: 01 wins
        step(1, 3, 21, 0, 0, 0, "R8");  // one entry freed
        idle(30);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int v, u, d, a, b;
            v = ($urandom % 5 != 0) ? 1 : 0;
            u = $urandom % 8;
            d = $urandom % 8;
            a = $urandom % 8;
            b = $urandom % 8;
            step(v, u, d, a, b, -1, "R9");
        end
        idle(30);
        finish_run();
    end

endmodule